// File: doc/BRIEF.md
# Fine-Grained 71-Bit Elapsed-Time Register

This block holds a running elapsed-time count measured in oscillator ticks. The count is 71 bits wide and is presented as two 36-bit words. The upper word uses all 36 bits. The lower word carries 35 magnitude bits, and its top bit is always zero. Internally only the part of the count above the 12-bit prescaler field is kept. A one-cycle pulse that marks a prescaler wrap advances the count by 4096 ticks.

Software can overwrite the count through a load port. The load port is always ready, so every cycle with the load valid signal high commits a load. Reads use a request/response pair. A request that is accepted captures both words from one and the same cycle. The captured value has the upper bits of the live prescaler spliced into its low field, which gives sub-wrap resolution. The response is held in a one-entry output register until it is consumed.

Back-pressure works as follows. A request is accepted only when the output register is empty, or when its current contents are being consumed in the same cycle (`rq_ready = !rs_valid || rs_ready`). While `rs_valid` is high and `rs_ready` is low, the response words do not change. Any request presented during that time waits.

Top module: `tbc_top`

## Requirements
- R1: After reset the stored count is zero and no response is pending; a read taken with a zero prescaler returns both words zero.
- R2: Each cycle with `pre_wrap` high and no load adds 4096 to the 71-bit count, as seen in later reads.
- R3: A carry out of the lower word's 35 magnitude bits increments the upper word. The full 71-bit count wraps to zero past its maximum.
- R4: A read returns `pre_cnt[11:2]` in bits [11:2] of the lower response word. The bits above bit 11 come from the stored count.
- R5: Bits [1:0] of the lower response word are always zero, whatever the prescaler value.
- R6: Bit 35 of the lower response word is always zero.
- R7: A load takes `ld_hi` whole. From `ld_lo` it keeps only bits [34:12]. Bits [11:0] and bit 35 of `ld_lo` have no effect on the stored count.
- R8: When a load and `pre_wrap` occur in the same cycle, the load wins and the wrap adds nothing.
- R9: An accepted read returns the count as it stands after that cycle's load or increment, both words from that single instant.
- R10: `rq_ready` equals `!rs_valid || rs_ready`. While `rs_valid` is high and `rs_ready` is low, the response words and `rs_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_wrap | input | 1 | One-cycle pulse on each prescaler wrap |
| pre_cnt | input | 12 | Live prescaler value |
| ld_valid | input | 1 | Load the count this cycle |
| ld_ready | output | 1 | Load port ready (always high) |
| ld_hi | input | 36 | Upper word to load |
| ld_lo | input | 36 | Lower word to load |
| rq_valid | input | 1 | Read request |
| rq_ready | output | 1 | Read request accepted this cycle |
| rs_valid | output | 1 | Response words valid |
| rs_ready | input | 1 | Consumer takes the response |
| rs_hi | output | 36 | Captured upper word |
| rs_lo | output | 36 | Captured lower word with merged prescaler bits |

## Verification
A stored count that has gone wrong stays wrong: every later response carries the error in bits above 11. It therefore shows at the first read accepted after the fault, one cycle after the request. An error in the carry path shows only when the lower field is all ones, so loads that place the count just below a carry boundary are followed at once by a wrap pulse and a read. Mistakes in the merge show in the low 12 bits of the very response being checked. Mistakes in the hold logic show as changed response words in a cycle where the consumer is stalled.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  // Which source feeds the stored count on the next edge.
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_STEP = 2'd1,
    UPD_LOAD = 2'd2
  } tbc_upd_e;

endpackage

// File: rtl/tbc_next.sv
module tbc_next #(
  parameter int HI_W  = 36,
  parameter int LO_W  = 35,
  parameter int PRE_W = 12
) (
  input  logic [HI_W-1:0]       st_hi,
  input  logic [LO_W-PRE_W-1:0] st_fld,
  input  logic                  pre_wrap,
  input  logic                  ld_fire,
  input  logic [HI_W-1:0]       ld_hi,
  input  logic [LO_W:0]         ld_lo,
  output logic [HI_W-1:0]       nx_hi,
  output logic [LO_W-PRE_W-1:0] nx_fld
);
  import tbc_pkg::*;

  localparam int FLD_W  = LO_W - PRE_W;
  localparam int WORD_W = LO_W + 1;

  tbc_upd_e          upd;
  logic [FLD_W-1:0]  fld_inc;
  logic              fld_cy;

  // Keep only the magnitude bits above the prescaler field.
  function automatic logic [FLD_W-1:0] take_field(input logic [WORD_W-1:0] w);
    return w[LO_W-1:PRE_W];
  endfunction

  always_comb begin
    if (ld_fire)       upd = UPD_LOAD;
    else if (pre_wrap) upd = UPD_STEP;
    else               upd = UPD_HOLD;
  end

  always_comb begin
    {fld_cy, fld_inc} = {1'b0, st_fld} + {{FLD_W{1'b0}}, 1'b1};
  end

  always_comb begin
    nx_hi  = st_hi;
    nx_fld = st_fld;
    case (upd)
      UPD_LOAD: begin
        nx_hi  = ld_hi;
        nx_fld = take_field(ld_lo);
      end
      UPD_STEP: begin
        nx_fld = fld_inc;
        nx_hi  = st_hi + {{(HI_W-1){1'b0}}, fld_cy};
      end
      default: begin
        nx_hi  = st_hi;
        nx_fld = st_fld;
      end
    endcase
  end

endmodule

// File: rtl/tbc_store.sv
module tbc_store #(
  parameter int HI_W  = 36,
  parameter int FLD_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HI_W-1:0]  nx_hi,
  input  logic [FLD_W-1:0] nx_fld,
  output logic [HI_W-1:0]  st_hi,
  output logic [FLD_W-1:0] st_fld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_hi  <= '0;
      st_fld <= '0;
    end else begin
      st_hi  <= nx_hi;
      st_fld <= nx_fld;
    end
  end

endmodule

// File: rtl/tbc_merge.sv
module tbc_merge #(
  parameter int HI_W  = 36,
  parameter int LO_W  = 35,
  parameter int PRE_W = 12,
  parameter int RAZ_W = 2
) (
  input  logic [HI_W-1:0]       nx_hi,
  input  logic [LO_W-PRE_W-1:0] nx_fld,
  input  logic [PRE_W-1:0]      pre_cnt,
  output logic [HI_W-1:0]       w_hi,
  output logic [LO_W:0]         w_lo
);

  localparam int FINE_W = PRE_W - RAZ_W;

  // Upper prescaler bits that are exposed to the reader.
  function automatic logic [FINE_W-1:0] fine_bits(input logic [PRE_W-1:0] c);
    return c[PRE_W-1:RAZ_W];
  endfunction

  assign w_hi = nx_hi;

  generate
    if (RAZ_W > 0) begin : g_raz
      assign w_lo = {1'b0, nx_fld, fine_bits(pre_cnt), {RAZ_W{1'b0}}};
    end else begin : g_full
      assign w_lo = {1'b0, nx_fld, fine_bits(pre_cnt)};
    end
  endgenerate

endmodule

// File: rtl/tbc_snap.sv
module tbc_snap #(
  parameter int HI_W   = 36,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HI_W-1:0]   cap_hi,
  input  logic [WORD_W-1:0] cap_lo,
  input  logic              rq_valid,
  output logic              rq_ready,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [HI_W-1:0]   rs_hi,
  output logic [WORD_W-1:0] rs_lo
);

  logic rq_fire;

  assign rq_ready = !rs_valid || rs_ready;
  assign rq_fire  = rq_valid && rq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hi    <= '0;
      rs_lo    <= '0;
    end else begin
      if (rq_fire) begin
        rs_valid <= 1'b1;
        rs_hi    <= cap_hi;
        rs_lo    <= cap_lo;
      end else if (rs_ready) begin
        rs_valid <= 1'b0;
      end
    end
  end

  // R10: a stalled response does not move
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_hi) && $stable(rs_lo)));

  // R10: an accepted request yields a pending response next cycle
  a_r10_fire_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready) |=> rs_valid);

endmodule

// File: rtl/tbc_top.sv
module tbc_top #(
  parameter int HI_W  = 36,
  parameter int LO_W  = 35,
  parameter int PRE_W = 12,
  parameter int RAZ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_wrap,
  input  logic [PRE_W-1:0] pre_cnt,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [HI_W-1:0]  ld_hi,
  input  logic [LO_W:0]    ld_lo,
  input  logic             rq_valid,
  output logic             rq_ready,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic [HI_W-1:0]  rs_hi,
  output logic [LO_W:0]    rs_lo
);

  localparam int FLD_W  = LO_W - PRE_W;
  localparam int WORD_W = LO_W + 1;
  localparam int CUR_W  = HI_W + FLD_W;
  localparam logic [WORD_W-1:0] RAZ_MASK = WORD_W'((64'd1 << RAZ_W) - 64'd1);

  logic [HI_W-1:0]   st_hi, nx_hi, w_hi;
  logic [FLD_W-1:0]  st_fld, nx_fld;
  logic [WORD_W-1:0] w_lo;
  logic [CUR_W-1:0]  cur;

  assign ld_ready = 1'b1;
  assign cur      = {st_hi, st_fld};

  tbc_next #(.HI_W(HI_W), .LO_W(LO_W), .PRE_W(PRE_W)) next_i (
    .st_hi    (st_hi),
    .st_fld   (st_fld),
    .pre_wrap (pre_wrap),
    .ld_fire  (ld_valid),
    .ld_hi    (ld_hi),
    .ld_lo    (ld_lo),
    .nx_hi    (nx_hi),
    .nx_fld   (nx_fld)
  );

  tbc_store #(.HI_W(HI_W), .FLD_W(FLD_W)) store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .nx_hi  (nx_hi),
    .nx_fld (nx_fld),
    .st_hi  (st_hi),
    .st_fld (st_fld)
  );

  tbc_merge #(.HI_W(HI_W), .LO_W(LO_W), .PRE_W(PRE_W), .RAZ_W(RAZ_W)) merge_i (
    .nx_hi   (nx_hi),
    .nx_fld  (nx_fld),
    .pre_cnt (pre_cnt),
    .w_hi    (w_hi),
    .w_lo    (w_lo)
  );

  tbc_snap #(.HI_W(HI_W), .WORD_W(WORD_W)) snap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_hi   (w_hi),
    .cap_lo   (w_lo),
    .rq_valid (rq_valid),
    .rq_ready (rq_ready),
    .rs_valid (rs_valid),
    .rs_ready (rs_ready),
    .rs_hi    (rs_hi),
    .rs_lo    (rs_lo)
  );

  // R2 and R3: one wrap step adds one unit above the prescaler field, carrying into the upper word
  a_r2_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wrap && !ld_valid) |=> (cur == CUR_W'($past(cur) + 1'b1)));

  // R7 and R8: a load wins and keeps only the field bits of the lower word
  a_r7_load_take: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (st_hi == $past(ld_hi) && st_fld == $past(ld_lo[LO_W-1:PRE_W])));

  // R2: without wrap or load the count holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_wrap && !ld_valid) |=> $stable(cur));

  // R9: the captured words equal the count after the capture cycle
  a_r9_same_instant: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready) |=> (rs_hi == st_hi && rs_lo[LO_W-1:PRE_W] == st_fld));

  // R5: lowest bits of a response read as zero
  a_r5_raz_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> ((rs_lo & RAZ_MASK) == '0));

  // R6: sign bit of the lower response word is clear
  a_r6_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> !rs_lo[LO_W]);

endmodule

// File: tb/tbc_top_tb_top.sv
`timescale 1ns/1ps
module tbc_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_wrap;
  logic [11:0] pre_cnt;
  logic        ld_valid;
  logic        ld_ready;
  logic [35:0] ld_hi;
  logic [35:0] ld_lo;
  logic        rq_valid;
  logic        rq_ready;
  logic        rs_valid;
  logic        rs_ready;
  logic [35:0] rs_hi;
  logic [35:0] rs_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [70:0] model;
  logic [71:0] exp_snap;
  bit          exp_valid;

  always #4 clk = ~clk;

  tbc_top dut_i (
    .clk(clk), .rst_n(rst_n), .pre_wrap(pre_wrap), .pre_cnt(pre_cnt),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rs_valid(rs_valid),
    .rs_ready(rs_ready), .rs_hi(rs_hi), .rs_lo(rs_lo)
  );

  function automatic logic [71:0] mk(input logic [70:0] m, input logic [11:0] pc);
    return {m[70:35], 1'b0, m[34:12], pc[11:2], 2'b00};
  endfunction

  function automatic logic [70:0] ld_val(input logic [35:0] h, input logic [35:0] l);
    return {h, l[34:12], 12'h000};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit ld, input logic [35:0] lh, input logic [35:0] ll,
                     input bit rq, input logic [11:0] pc, input bit rr, input string tag);
    bit acc;
    pre_wrap = tk; ld_valid = ld; ld_hi = lh; ld_lo = ll;
    rq_valid = rq; pre_cnt = pc; rs_ready = rr;
    #1;
    chk(rq_ready == (!exp_valid || rr), {tag, " R10 rq_ready"}, {71'd0, rq_ready}, {71'd0, (!exp_valid || rr)});
    chk(ld_ready == 1'b1, {tag, " R7 ld_ready"}, {71'd0, ld_ready}, 72'd1);
    acc = rq && (!exp_valid || rr);
    if (ld)      model = ld_val(lh, ll);
    else if (tk) model = model + 71'd4096;
    if (acc) begin
      exp_snap  = mk(model, pc);
      exp_valid = 1'b1;
    end else if (rr) begin
      exp_valid = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rs_valid == exp_valid, {tag, " R10 rs_valid"}, {71'd0, rs_valid}, {71'd0, exp_valid});
    if (exp_valid)
      chk({rs_hi, rs_lo} == exp_snap, {tag, " words"}, {rs_hi, rs_lo}, exp_snap);
  endtask

  task automatic idle(input bit tk);
    cyc(tk, 0, '0, '0, 0, '0, 1, "R2 idle");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_0a17));
    rst_n = 0; pre_wrap = 0; pre_cnt = '0; ld_valid = 0; ld_hi = '0; ld_lo = '0;
    rq_valid = 0; rs_ready = 1;
    model = '0; exp_valid = 0; exp_snap = '0;
    repeat (4) @(negedge clk);
    chk(rs_valid == 1'b0, "R1 rs_valid in reset", {71'd0, rs_valid}, 72'd0);
    rst_n = 1;

    // R1: zero after reset
    cyc(0, 0, '0, '0, 1, 12'h000, 1, "R1 read after reset");
    chk({rs_hi, rs_lo} == 72'd0, "R1 zero count", {rs_hi, rs_lo}, 72'd0);

    // R2: three wraps
    idle(1); idle(1); idle(1);
    cyc(0, 0, '0, '0, 1, 12'h000, 1, "R2 three wraps");
    chk(rs_lo == 36'h000003000, "R2 count value", {36'd0, rs_lo}, 72'h3000);

    // R9: read in the same cycle as a wrap sees the new count
    cyc(1, 0, '0, '0, 1, 12'h000, 1, "R9 read with wrap");
    chk(rs_lo == 36'h000004000, "R9 includes wrap", {36'd0, rs_lo}, 72'h4000);

    // R4 and R5: prescaler merge
    cyc(0, 0, '0, '0, 1, 12'hABF, 1, "R4 merge ABF");
    chk(rs_lo[11:0] == 12'hABC, "R4 fine bits", {60'd0, rs_lo[11:0]}, 72'hABC);
    cyc(0, 0, '0, '0, 1, 12'hFFF, 1, "R5 merge FFF");
    chk(rs_lo[1:0] == 2'b00, "R5 low bits zero", {70'd0, rs_lo[1:0]}, 72'd0);

    // R7 and R6: load discards low field and sign
    cyc(0, 1, 36'h123456789, 36'hFFFFFFFFF, 1, 12'h000, 1, "R7 load");
    chk(rs_lo == 36'h7FFFFF000, "R7 low word after load", {36'd0, rs_lo}, {36'd0, 36'h7FFFFF000});
    chk(rs_lo[35] == 1'b0, "R6 sign clear", {71'd0, rs_lo[35]}, 72'd0);

    // R3: carry into upper word
    cyc(1, 0, '0, '0, 1, 12'h000, 1, "R3 carry");
    chk(rs_hi == 36'h12345678A && rs_lo == 36'd0, "R3 carry result", {rs_hi, rs_lo}, {36'h12345678A, 36'd0});

    // R3: full wrap to zero
    cyc(0, 1, 36'hFFFFFFFFF, 36'h7FFFFF123, 0, 12'h000, 1, "R3 load max");
    cyc(1, 0, '0, '0, 1, 12'h000, 1, "R3 wrap to zero");
    chk({rs_hi, rs_lo} == 72'd0, "R3 wrapped", {rs_hi, rs_lo}, 72'd0);

    // R8: load beats wrap
    cyc(1, 1, 36'h000000055, 36'h000005000, 1, 12'h000, 1, "R8 load and wrap");
    chk(rs_lo == 36'h000005000 && rs_hi == 36'h55, "R8 load wins", {rs_hi, rs_lo}, {36'h55, 36'h5000});

    // R10: stall holds response, waiting request refused
    cyc(0, 0, '0, '0, 1, 12'h100, 0, "R10 stalled capture");
    cyc(1, 0, '0, '0, 1, 12'hFFF, 0, "R10 stalled hold");
    cyc(1, 0, '0, '0, 1, 12'h3F0, 1, "R10 consume and refill");
    cyc(0, 0, '0, '0, 0, 12'h000, 1, "R10 drain");

    // random phase
    for (int i = 0; i < 1500; i++) begin
      bit tk, ld, rq, rr;
      logic [35:0] lh, ll;
      tk = ($urandom % 3) == 0;
      ld = ($urandom % 11) == 0;
      rq = ($urandom % 2) == 0;
      rr = ($urandom % 4) != 0;
      lh = {$urandom, $urandom} & 36'hFFFFFFFFF;
      ll = {$urandom, $urandom} & 36'hFFFFFFFFF;
      if (($urandom % 5) == 0) ll = ll | 36'h7FFFFF000;
      cyc(tk, ld, lh, ll, rq, 12'($urandom), rr, "R2 R4 R7 R9 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule